// File: doc/BRIEF.md
# Address/Data Breakpoint Comparator

This block watches a CPU bus that has one address bus, a read data bus and a separate write data bus. A direction strobe tells the block whether the current cycle is a read or a write. When a valid bus cycle meets the programmed condition, the block raises a match pulse one clock later. A sticky status bit records that a match has occurred.

In full mode, both the address and the data must equal their programmed values. Bits set in a mask register are don't-care bits in the data comparison. The block compares only the data bus that carries the current cycle. A read therefore uses the read bus and a write uses the write bus, so a value sitting on the idle bus can never cause a match. A direction qualifier can also limit matches to reads only or to writes only. In address-only mode the data buses play no part at all.

Four configuration registers are written through a simple select/strobe port. Trace capture and CPU halting are left to neighbouring logic.

Top module: `bkpt_cmp`

## Requirements
- R1: After reset, `hit` and `hit_sticky` are 0, and every configuration register is 0. With enable clear, no match can occur.
- R2: In full mode (CTRL bit 1 = 1), a valid cycle matches only if two things hold:
  - the address equals the ADDR register;
  - the active data equals the DATA register in every bit that is not masked.
- R3: With direction qualification off (CTRL bit 2 = 0), the active data is chosen by the cycle type:
  - a read (`bus_wr` = 0) compares `bus_rdata`;
  - a write (`bus_wr` = 1) compares `bus_wdata`.
  A matching value on the inactive bus never produces a match.
- R4: With direction qualification on (CTRL bit 2 = 1), a match occurs only on cycles whose `bus_wr` equals CTRL bit 3 (0 = reads, 1 = writes).
- R5: In address-only mode (CTRL bit 1 = 0), both data buses and the DATA and MASK registers are ignored, and an address match alone produces a match.
- R6: A 1 in a MASK register bit makes the same data bit a don't-care.
- R7: `hit` is high for exactly the one clock that follows the rising edge at which a matching cycle was sampled with `bus_valid` = 1. There is no pulse when `bus_valid` = 0 or when CTRL bit 0 (enable) = 0.
- R8: A match sets `hit_sticky`. Writing CTRL with bit 4 = 1 clears it; bit 4 is not stored. When a match and a clear fall in the same cycle, the set wins.
- R9: Register select values are:
  - 0 = CTRL;
  - 1 = ADDR;
  - 2 = DATA;
  - 3 = MASK.
  Each register takes the low bits of `cfg_wdata` on a clock edge with `cfg_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| bus_valid | input | 1 | Bus cycle valid this clock |
| bus_wr | input | 1 | Cycle direction: 1 write, 0 read |
| bus_addr | input | AW | Bus address |
| bus_rdata | input | DW | Read data bus |
| bus_wdata | input | DW | Write data bus |
| hit | output | 1 | One-cycle match pulse |
| hit_sticky | output | 1 | Sticky match status |

## Verification
The embedded assertions check several rules on every clock:
- each pulse follows a valid, enabled cycle;
- a qualified pulse has the selected direction;
- every full-mode pulse agrees with the unmasked bits of the bus that carried the cycle;
- the sticky bit follows its set and clear rule.

Some behaviour only the bench scenarios can show. These are the missed matches: the cases where a matching cycle should produce a pulse and none comes. Mask and mode changes and reset values also fall to the bench. The bench covers them with a vector table and directed cases.

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          bus_valid,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] bus_wdata,
  output logic          hit,
  output logic          hit_sticky
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  logic          en_q, full_q, qual_q, dir_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, mask_q;

  wire           clr_w    = cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[4];
  wire [DW-1:0]  act_data = bus_wr ? bus_wdata : bus_rdata;
  wire           addr_eq  = bus_addr == addr_q;
  wire           data_eq  = ((act_data ^ data_q) & ~mask_q) == '0;
  wire           dir_ok   = !qual_q || (bus_wr == dir_q);
  wire           match    = bus_valid && en_q && addr_eq && dir_ok && (!full_q || data_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; full_q <= 1'b0; qual_q <= 1'b0; dir_q <= 1'b0;
      addr_q <= '0; data_q <= '0; mask_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: {dir_q, qual_q, full_q, en_q} <= cfg_wdata[3:0];
        SEL_ADDR: addr_q <= cfg_wdata[AW-1:0];
        SEL_DATA: data_q <= cfg_wdata[DW-1:0];
        SEL_MASK: mask_q <= cfg_wdata[DW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= 1'b0;
      hit_sticky <= 1'b0;
    end else begin
      hit        <= match;
      hit_sticky <= match || (hit_sticky && !clr_w);
    end
  end

  assert_pulse_from_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(bus_valid) && $past(en_q));

  assert_direction_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && $past(qual_q) |-> $past(bus_wr) == $past(dir_q));

  assert_active_bus_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && $past(full_q) |->
      ((($past(bus_wr) ? $past(bus_wdata) : $past(bus_rdata)) ^ $past(data_q)) & ~$past(mask_q)) == '0);

  assert_sticky_follows_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_sticky);

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_w) && !hit |-> !hit_sticky);

  assert_address_required_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(bus_addr) == $past(addr_q));
endmodule

// File: tb/tb_bkpt_cmp.sv
`timescale 1ns/1ps
module tb_bkpt_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_rdata = '0, bus_wdata = '0;
  logic        hit, hit_sticky;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bkpt_cmp dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .hit(hit), .hit_sticky(hit_sticky));

  // {wr, addr, rdata, wdata, expected hit}; full mode, ADDR=1234, DATA=ABCD, no mask
  localparam logic [49:0] VEC [0:7] = '{
    {1'b0, 16'h1234, 16'hABCD, 16'h0000, 1'b1},
    {1'b0, 16'h1234, 16'h0000, 16'hABCD, 1'b0},
    {1'b1, 16'h1234, 16'h0000, 16'hABCD, 1'b1},
    {1'b1, 16'h1234, 16'hABCD, 16'h0000, 1'b0},
    {1'b0, 16'h1235, 16'hABCD, 16'hABCD, 1'b0},
    {1'b1, 16'h0234, 16'hABCD, 16'hABCD, 1'b0},
    {1'b0, 16'h1234, 16'hABCC, 16'hABCD, 1'b0},
    {1'b1, 16'h1234, 16'hABCD, 16'hABCD, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic wr, input logic [15:0] a, input logic [15:0] rd,
                     input logic [15:0] wd, input logic exp, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = wr; bus_addr = a; bus_rdata = rd; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(hit, exp, req);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hit, 1'b0, "R1 hit reset");
    chk(hit_sticky, 1'b0, "R1 sticky reset");
    rst_n = 1'b1;
    cyc(1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R1 disabled after reset");

    cfg(2'd1, 32'h1234);
    cfg(2'd2, 32'hABCD);
    cfg(2'd3, 32'h0);
    cfg(2'd0, 32'h3);
    for (int i = 0; i < 8; i++)
      cyc(VEC[i][49], VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], "R2/R3 vector");

    cyc(1'b0, 16'h1234, 16'hABCD, 16'h0, 1'b1, "R7 pulse");
    @(negedge clk); chk(hit, 1'b0, "R7 single cycle");
    @(negedge clk); bus_valid = 1'b0; bus_addr = 16'h1234; bus_rdata = 16'hABCD;
    @(negedge clk); chk(hit, 1'b0, "R7 no valid");

    cfg(2'd3, 32'h000F);
    cyc(1'b0, 16'h1234, 16'hABC0, 16'h0, 1'b1, "R6 masked low nibble");
    cyc(1'b0, 16'h1234, 16'hBBCD, 16'h0, 1'b0, "R6 unmasked bit differs");

    cfg(2'd0, 32'h1);
    cyc(1'b1, 16'h1234, 16'h5555, 16'h6666, 1'b1, "R5 address only");
    cyc(1'b1, 16'h1230, 16'hABCD, 16'hABCD, 1'b0, "R5 address miss");

    cfg(2'd0, 32'h7);
    cyc(1'b0, 16'h1234, 16'hABCD, 16'hABCD, 1'b1, "R4 read selected");
    cyc(1'b1, 16'h1234, 16'hABCD, 16'hABCD, 1'b0, "R4 write rejected");
    cfg(2'd0, 32'hF);
    cyc(1'b1, 16'h1234, 16'h0, 16'hABCD, 1'b1, "R4 write selected");
    cyc(1'b0, 16'h1234, 16'hABCD, 16'hABCD, 1'b0, "R4 read rejected");

    chk(hit_sticky, 1'b1, "R8 sticky set");
    cfg(2'd0, 32'h1F);
    @(negedge clk); chk(hit_sticky, 1'b0, "R8 sticky cleared");
    cyc(1'b1, 16'h1234, 16'h0, 16'hABCD, 1'b1, "R9 bit4 not stored, ctrl kept");

    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 16'h1234; bus_wdata = 16'hABCD;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h1F;
    @(negedge clk); bus_valid = 1'b0; cfg_we = 1'b0;
    chk(hit_sticky, 1'b1, "R8 set wins over clear");

    cfg(2'd0, 32'hE);
    cyc(1'b1, 16'h1234, 16'h0, 16'hABCD, 1'b0, "R7 disabled");

    rst_n = 1'b0;
    @(negedge clk);
    chk(hit_sticky, 1'b0, "R1 reset clears sticky");
    rst_n = 1'b1;
    cyc(1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R1 config cleared by reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule